// File: doc/BRIEF.md
# Serial Real-Time Clock Slave

This block answers a host that toggles three wires by software: a frame enable, a serial clock and a data bit. One frame is sixteen falling clock edges long. The first eight edges carry a command byte and the last eight carry a value byte, both most significant bit first. If the command names a readable location, the block shifts that location's byte back on its own data output while the value byte is being clocked in.

Behind the serial port sit a small non-volatile byte store, a status byte, a fixed control byte and a time-of-day view. The time-of-day view converts binary time inputs, supplied by logic outside the block, into two-digit packed BCD. A write to the byte store takes effect once the sixteenth edge has arrived. An acknowledge command clears two status flags and sends a one-cycle request to the interrupt logic to clear its matching bit. All pins are sampled in the system clock domain, and a falling serial clock edge is recognised one system clock after it arrives.

Top module: `serial_rtc_slave`

## Requirements
- R1: Following reset, `sdo_o`, `sdo_oe_o` and `irq_clr_o` are all 0, the status byte is 0x90, and every byte-store location `i` holds byte `i` of `RAM_INIT`, with byte 0 in bits 7:0.
- R2: A bit is shifted only when the system clock finds `sclk_i` falling while `sel_i` is high. Rising edges and any toggling while `sel_i` is low change nothing. Edges 1 to 8 fill the command byte and edges 9 to 16 fill the value byte, each MSB first.
- R3: For a command below `NV_BYTES`, byte-store location [command] is returned. Bit 7 appears on `sdo_o` at the 9th edge and the following bits appear one per edge after it. `sdo_oe_o` is 1 from the 9th edge until `sel_i` falls.
- R4: Command 0x30 returns the status byte and command 0x31 returns the `CTRL_INIT` byte, timed as in R3.
- R5: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return packed BCD of seconds, minutes, hours, day of month, month and (year − 2000). Every other command from 0x20 to 0x2F returns 0x00 with `sdo_oe_o` high.
- R6: At the 16th edge, a command from 0x80 to 0x80+`NV_BYTES`−1 stores the value byte at location command − 0x80.
- R7: At the 16th edge, command 0xB1 with value bit 2 set clears status bits 4 and 3 and raises `irq_clr_o` for exactly one cycle. With value bit 2 clear, it does neither.
- R8: A low `sel_i` aborts the frame. The edge count, command and value are cleared, `sdo_o` goes to 0 and `sdo_oe_o` goes to 0. An edge arriving in the same cycle as the abort is dropped, so a 16th edge that coincides with it stores nothing.
- R9: After the 16th edge, further edges are ignored until `sel_i` falls. No second command is decoded and nothing more is written.
- R10: Any other command (for example 0x32 or 0x40) keeps `sdo_oe_o` and `sdo_o` low and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Frame enable from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| tod_sec_i | input | 6 | Seconds, binary 0–59 |
| tod_min_i | input | 6 | Minutes, binary 0–59 |
| tod_hour_i | input | 5 | Hours, binary 0–23 |
| tod_mday_i | input | 5 | Day of month, binary 1–31 |
| tod_mon_i | input | 4 | Month, binary 1–12 |
| tod_year_i | input | 12 | Full year, 2000–2099 |
| sdo_o | output | 1 | Serial data returned to the host |
| sdo_oe_o | output | 1 | High while `sdo_o` carries returned data |
| irq_clr_o | output | 1 | One-cycle request to clear interrupt-status bit 2 |

## Verification
Two events can land in the same system clock cycle: the abort caused by `sel_i` dropping, and the 16th falling edge that would commit a write. The bench sends fifteen bits of a write frame to location 6. It then lowers `sclk_i` and `sel_i` at the same instant and reads location 6 back; the check passes only if the reset value is still there. A second pairing is the final value bit and the commit of that bit. Writing 0xA5 and reading it back shows whether the store received the value byte including its last bit, and not the byte as it stood one shift earlier.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef logic [7:0] byte_t;

   localparam byte_t CMD_TIME_HI = 8'h20;   // upper nibble 2: time window
   localparam byte_t CMD_STATUS  = 8'h30;
   localparam byte_t CMD_CONTROL = 8'h31;
   localparam byte_t CMD_WR_BASE = 8'h80;
   localparam byte_t CMD_ACK     = 8'hB1;
   localparam byte_t ACK_MASK    = 8'h18;   // status flags cleared by ack
   localparam int    TIME_FIELDS = 6;

   function automatic byte_t to_bcd(input logic [6:0] v);
      logic [6:0] tens;
      logic [6:0] ones;
      tens = v / 7'd10;
      ones = v - tens * 7'd10;
      return {tens[3:0], ones[3:0]};
   endfunction
endpackage

// File: rtl/rtc_bcd_pack.sv
module rtc_bcd_pack
   import rtc_pkg::*;
#(
   parameter int N = TIME_FIELDS
) (
   input  logic [N-1:0][6:0] bin_i,
   output logic [N-1:0][7:0] bcd_o
);
   for (genvar g = 0; g < N; g++) begin : g_field
      assign bcd_o[g] = to_bcd(bin_i[g]);
   end
endmodule

// File: rtl/rtc_frame_ctrl.sv
module rtc_frame_ctrl #(
   parameter int BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_i,
   input  logic                  sclk_i,
   input  logic                  sdi_i,
   output logic                  shift_o,
   output logic                  commit_o,
   output logic [$clog2(2*BITS+1)-1:0] phase_o,
   output logic [BITS-1:0]       cmd_o,
   output logic [BITS-1:0]       val_next_o
);
   localparam int LAST = 2 * BITS;
   localparam int PW   = $clog2(LAST + 1);
   localparam logic [PW-1:0] LAST_P = PW'(LAST);
   localparam logic [PW-1:0] HALF_P = PW'(BITS);

   if (BITS < 2) begin : g_bad_bits
      $error("rtc_frame_ctrl: BITS must be at least 2");
   end

   logic          sclk_q;
   logic          fall;
   logic [PW-1:0] phase;
   logic [BITS-1:0] cmd, val;

   assign fall       = sel_i & sclk_q & ~sclk_i;
   assign shift_o    = fall & (phase < LAST_P);
   assign commit_o   = shift_o & (phase == LAST_P - 1'b1);
   assign val_next_o = {val[BITS-2:0], sdi_i};
   assign phase_o    = phase;
   assign cmd_o      = cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         phase  <= '0;
         cmd    <= '0;
         val    <= '0;
      end else begin
         sclk_q <= sclk_i;
         if (!sel_i) begin
            phase <= '0;
            cmd   <= '0;
            val   <= '0;
         end else if (shift_o) begin
            phase <= phase + 1'b1;
            if (phase < HALF_P) cmd <= {cmd[BITS-2:0], sdi_i};
            else                val <= val_next_o;
         end
      end
   end

   assert_phase_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= LAST_P);
   assert_hold_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && phase == LAST_P) |=> phase == LAST_P);
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && sclk_q && !sclk_i && phase < LAST_P) |=> phase == $past(phase) + 1'b1);
   assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> (phase == '0 && cmd == '0 && val == '0));
endmodule

// File: rtl/rtc_nv_store.sv
module rtc_nv_store
   import rtc_pkg::*;
#(
   parameter int                      NV_BYTES  = 32,
   parameter logic [NV_BYTES*8-1:0]   RAM_INIT  = '0,
   parameter byte_t                   STAT_INIT = 8'h90,
   localparam int                     AW        = $clog2(NV_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  byte_t         wr_data_i,
   input  logic [AW-1:0] rd_addr_i,
   input  logic          ack_i,
   output byte_t         rd_data_o,
   output byte_t         status_o,
   output logic          irq_clr_o
);
   byte_t mem [NV_BYTES];
   byte_t status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NV_BYTES; i++) mem[i] <= RAM_INIT[i*8 +: 8];
         status    <= STAT_INIT;
         irq_clr_o <= 1'b0;
      end else begin
         if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
         if (ack_i)   status <= status & ~ACK_MASK;
         irq_clr_o <= ack_i;
      end
   end

   assign rd_data_o = mem[rd_addr_i];
   assign status_o  = status;

   assert_ram_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> mem[$past(wr_addr_i)] == $past(wr_data_i));
   assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr_o |-> (status_o[4:3] == 2'b00));
   assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr_o |=> !irq_clr_o);
endmodule

// File: rtl/serial_rtc_slave.sv
module serial_rtc_slave
   import rtc_pkg::*;
#(
   parameter int                    NV_BYTES  = 32,
   parameter logic [NV_BYTES*8-1:0] RAM_INIT  = '0,
   parameter byte_t                 STAT_INIT = 8'h90,
   parameter byte_t                 CTRL_INIT = 8'h00,
   parameter bit                    TIME_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel_i,
   input  logic        sclk_i,
   input  logic        sdi_i,
   input  logic [5:0]  tod_sec_i,
   input  logic [5:0]  tod_min_i,
   input  logic [4:0]  tod_hour_i,
   input  logic [4:0]  tod_mday_i,
   input  logic [3:0]  tod_mon_i,
   input  logic [11:0] tod_year_i,
   output logic        sdo_o,
   output logic        sdo_oe_o,
   output logic        irq_clr_o
);
   localparam int    BITS   = 8;
   localparam int    PW     = $clog2(2*BITS+1);
   localparam int    AW     = $clog2(NV_BYTES);
   localparam byte_t RAM_LIM = byte_t'(NV_BYTES);
   localparam logic [8:0] WR_END = 9'(128 + NV_BYTES);
   localparam logic [PW-1:0] HALF_P = PW'(BITS);

   if (NV_BYTES < 2 || NV_BYTES > 32 || (NV_BYTES & (NV_BYTES - 1)) != 0) begin : g_bad_depth
      $error("serial_rtc_slave: NV_BYTES must be a power of two from 2 to 32");
   end

   logic            shift, commit;
   logic [PW-1:0]   phase;
   byte_t           cmd, val_next;
   byte_t           ram_byte, status, time_byte, rd_byte;
   logic            is_ram, is_time, is_stat, is_ctl, is_rd, is_wr, ack;
   logic            sdo_q;
   logic [TIME_FIELDS-1:0][6:0] tbin;
   logic [TIME_FIELDS-1:0][7:0] tbcd;

   rtc_frame_ctrl #(.BITS(BITS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
      .shift_o(shift), .commit_o(commit), .phase_o(phase),
      .cmd_o(cmd), .val_next_o(val_next)
   );

   // command decode
   assign is_ram  = cmd < RAM_LIM;
   assign is_time = cmd[7:4] == CMD_TIME_HI[7:4];
   assign is_stat = cmd == CMD_STATUS;
   assign is_ctl  = cmd == CMD_CONTROL;
   assign is_rd   = is_ram | is_time | is_stat | is_ctl;
   assign is_wr   = (cmd >= CMD_WR_BASE) && ({1'b0, cmd} < WR_END);
   assign ack     = commit & (cmd == CMD_ACK) & val_next[2];

   rtc_nv_store #(.NV_BYTES(NV_BYTES), .RAM_INIT(RAM_INIT), .STAT_INIT(STAT_INIT)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(commit & is_wr), .wr_addr_i(cmd[AW-1:0]), .wr_data_i(val_next),
      .rd_addr_i(cmd[AW-1:0]), .ack_i(ack),
      .rd_data_o(ram_byte), .status_o(status), .irq_clr_o(irq_clr_o)
   );

   // time-of-day view
   assign tbin[0] = {1'b0, tod_sec_i};
   assign tbin[1] = {1'b0, tod_min_i};
   assign tbin[2] = {2'b0, tod_hour_i};
   assign tbin[3] = {2'b0, tod_mday_i};
   assign tbin[4] = {3'b0, tod_mon_i};
   assign tbin[5] = 7'(tod_year_i - 12'd2000);

   if (TIME_EN) begin : g_time
      rtc_bcd_pack #(.N(TIME_FIELDS)) u_bcd (.bin_i(tbin), .bcd_o(tbcd));
   end else begin : g_no_time
      assign tbcd = '0;
   end

   always_comb begin
      case (cmd[3:0])
         4'h0:    time_byte = tbcd[0];
         4'h1:    time_byte = tbcd[1];
         4'h2:    time_byte = tbcd[2];
         4'h4:    time_byte = tbcd[3];
         4'h5:    time_byte = tbcd[4];
         4'h6:    time_byte = tbcd[5];
         default: time_byte = '0;
      endcase
   end

   always_comb begin
      if (is_ram)       rd_byte = ram_byte;
      else if (is_stat) rd_byte = status;
      else if (is_ctl)  rd_byte = CTRL_INIT;
      else if (is_time) rd_byte = time_byte;
      else              rd_byte = '0;
   end

   // return path: edge at phase 8+k presents bit 7-k
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           sdo_q <= 1'b0;
      else if (!sel_i)                      sdo_q <= 1'b0;
      else if (shift && phase >= HALF_P)    sdo_q <= rd_byte[~phase[2:0]];
   end

   assign sdo_o    = sdo_q;
   assign sdo_oe_o = sel_i & is_rd & (phase > HALF_P);

   assert_sdo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> !sdo_o);
   assert_no_drive_other_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && phase == HALF_P && !(cmd < RAM_LIM) && cmd[7:4] != 4'h2
       && cmd != CMD_STATUS && cmd != CMD_CONTROL) |=> !sdo_o);
endmodule

// File: tb/test_serial_rtc_slave.sv
module test_serial_rtc_slave;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
   logic sdo, sdo_oe, irq_clr;
   int   checks = 0, errors = 0, irq_cnt = 0;
   bit   done = 1'b0;

   function automatic logic [255:0] mk_init();
      logic [255:0] r;
      for (int i = 0; i < 32; i++) r[i*8 +: 8] = 8'(i * 37 + 11);
      return r;
   endfunction
   localparam logic [255:0] TB_INIT = mk_init();

   always #2 clk = ~clk;   // 250 MHz

   serial_rtc_slave #(.NV_BYTES(32), .RAM_INIT(TB_INIT), .STAT_INIT(8'h90),
                      .CTRL_INIT(8'h5A), .TIME_EN(1'b1)) i_serial_rtc_slave (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
      .tod_sec_i(6'd47), .tod_min_i(6'd5), .tod_hour_i(5'd23), .tod_mday_i(5'd31),
      .tod_mon_i(4'd12), .tod_year_i(12'd2037),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_clr_o(irq_clr)
   );

   always @(posedge clk) if (irq_clr) irq_cnt <= irq_cnt + 1;

   // {command, expected byte, expected oe}
   localparam int NV = 15;
   localparam logic [23:0] VEC [NV] = '{
      24'h000B01, 24'h1F8601, 24'h070E01, 24'h309001, 24'h315A01,
      24'h204701, 24'h210501, 24'h222301, 24'h243101, 24'h251201,
      24'h263701, 24'h230001, 24'h2F0001, 24'h400000, 24'h320000
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Sends nbits of pat (MSB first); collects bits returned at edges 9..16.
   task automatic frame(input logic [31:0] pat, input int nbits, input bit drop_last,
                        output logic [7:0] rd, output logic oe_end, output logic sdo_end);
      rd = '0;
      sel = 1'b1;
      @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdi  = pat[nbits-1-i];
         sclk = 1'b1;
         repeat (2) @(negedge clk);
         sclk = 1'b0;
         if (drop_last && i == nbits - 1) sel = 1'b0;
         repeat (2) @(negedge clk);
         if (i >= 8 && i < 16) rd = {rd[6:0], sdo};
      end
      oe_end  = sdo_oe;
      sdo_end = sdo;
      sel = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic rd_byte(input logic [7:0] c, output logic [7:0] rd, output logic oe);
      logic s;
      frame({16'h0, c, 8'hFF}, 16, 1'b0, rd, oe, s);
   endtask

   task automatic wr_byte(input logic [7:0] c, input logic [7:0] v);
      logic [7:0] rd;
      logic oe, s;
      frame({16'h0, c, v}, 16, 1'b0, rd, oe, s);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      logic oe, s;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 sdo", sdo, 0);
      check("R1 oe", sdo_oe, 0);
      check("R1 irq", irq_clr, 0);

      // vector table: reads (R3 store, R4 status/control, R5 time, R10 other)
      for (int k = 0; k < NV; k++) begin
         logic [7:0] c, e;
         string tag;
         c = VEC[k][23:16];
         e = VEC[k][15:8];
         if (c < 8'h20)                      tag = "R3";
         else if (c == 8'h30 || c == 8'h31)  tag = "R4";
         else if (c[7:4] == 4'h2)            tag = "R5";
         else                                tag = "R10";
         if (c == 8'h30) tag = "R1/R4";
         rd_byte(c, rd, oe);
         check($sformatf("%s data cmd %0h", tag, c), rd, e);
         check($sformatf("%s oe cmd %0h", tag, c), oe, VEC[k][0]);
      end
      check("R10 sdo low after other cmd", sdo, 0);

      // R2: toggling while deselected and rising edges do nothing
      sdi = 1'b1;
      for (int k = 0; k < 6; k++) begin
         sclk = ~sclk;
         repeat (2) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      rd_byte(8'h00, rd, oe);
      check("R2 idle toggles ignored", rd, 8'h0B);

      // R6 writes, including both ends of the write window
      wr_byte(8'h85, 8'hA5);
      rd_byte(8'h05, rd, oe);
      check("R6 write 0x85", rd, 8'hA5);
      wr_byte(8'h9F, 8'h3C);
      rd_byte(8'h1F, rd, oe);
      check("R6 write top 0x9F", rd, 8'h3C);
      wr_byte(8'h80, 8'h01);
      rd_byte(8'h00, rd, oe);
      check("R6 write base 0x80", rd, 8'h01);

      // R7 acknowledge
      wr_byte(8'hB1, 8'hFB);
      check("R7 no pulse without bit2", irq_cnt, 0);
      rd_byte(8'h30, rd, oe);
      check("R7 status kept", rd, 8'h90);
      wr_byte(8'hB1, 8'h04);
      check("R7 single pulse", irq_cnt, 1);
      rd_byte(8'h30, rd, oe);
      check("R7 status cleared", rd, 8'h80);

      // R9 edges after the 16th ignored
      frame({8'h84, 8'h11, 8'h84, 8'hEE}, 32, 1'b0, rd, oe, s);
      rd_byte(8'h04, rd, oe);
      check("R9 extra edges ignored", rd, 8'h11);

      // R8 abort mid-write
      frame({20'h0, 8'h83, 4'hF}, 12, 1'b0, rd, oe, s);
      rd_byte(8'h03, rd, oe);
      check("R8 aborted write", rd, 8'h7A);

      // R8 abort mid-read: drive stops and return clears
      sel = 1'b1;
      frame({19'h0, 8'h07, 5'h1F}, 13, 1'b0, rd, oe, s);
      check("R8 oe before abort", oe, 1);
      check("R8 sdo before abort", s, 1);
      check("R8 oe after abort", sdo_oe, 0);
      check("R8 sdo after abort", sdo, 0);

      // R8 abort coinciding with the 16th edge
      frame({16'h0, 8'h86, 8'h77}, 16, 1'b1, rd, oe, s);
      rd_byte(8'h06, rd, oe);
      check("R8 abort beats final edge", rd, 8'hE9);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule